// File: doc/BRIEF.md
# Pinned re-reference replacement state for one cache set

This block holds the replacement state of a single 16-way cache set. Every way carries a 2-bit re-reference prediction value (RRPV), a pin bit and a 2-bit texture-lifecycle state. An outside policy engine issues one operation per cycle: a read hit, a write hit, a fill or a victim search. It supplies the target way, the class of the stream that made the access, a pin request, an insertion value for fills and a promotion value for hits.

Victim searches follow static re-reference interval prediction. Pinned ways are never chosen. A pinned way gets a second chance instead: when its value reaches the maximum, the block clears its pin and sets its value back to zero. If every way is pinned, the block reports that no victim exists so that the fill can be bypassed. The texture state follows surfaces that a render stream writes and the texture sampler later reads. A replacement policy uses it to spot dynamic texture data that has had its last use.

Top module: `rrip_pin_set`

## Requirements
- R1: After reset, every way has RRPV 3, pin 0 and texture state 00, and victim_valid is 0.
- R2: A read hit (op 0) loads the way's RRPV from `promote_rrpv` and clears its pin bit.
- R3: A write hit (op 1) loads the way's RRPV from `promote_rrpv`. It sets the pin bit when `pin_req` is 1 and otherwise leaves the pin bit unchanged. Only a write hit or a fill can set a pin bit.
- R4: A fill (op 2) loads the way's RRPV from `insert_rrpv`, sets its pin bit to `pin_req` and sets its texture state to 00.
- R5: A victim search (op 3) ages all unpinned ways by the smallest amount that brings one of them to 3. It then reports the lowest-indexed unpinned way at 3, with victim_valid 1 in the following cycle.
- R6: A pinned way is never reported as a victim. Any way that would end a cycle pinned with RRPV 3, through aging or through a loaded value, instead ends that cycle with pin 0 and RRPV 0. A way released during a search is not aged any further in that search.
- R7: A victim search with all ways pinned reports victim_valid 0 and victim_way 0. It ages every way by one, and R6 applies.
- R8: A write hit from stream class color (1), depth (2) or blitter (3) sets the texture state to 01. Write hits from any other class leave it unchanged.
- R9: A read hit from the texture sampler (class 4) moves texture state 01 to 10 and 10 to 11. It leaves 00 and 11 unchanged. Read hits from other classes never change the texture state.
- R10: A cycle with `op_valid` low changes no state. The victim outputs hold their values until the next victim search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 read hit, 1 write hit, 2 fill, 3 victim search |
| way | input | 4 | Target way for hits and fills |
| stream | input | 3 | Stream class: 1 color, 2 depth, 3 blitter, 4 texture sampler, others generic |
| pin_req | input | 1 | Pin request from the policy (write hit, fill) |
| insert_rrpv | input | 2 | RRPV loaded on a fill |
| promote_rrpv | input | 2 | RRPV loaded on a hit |
| victim_way | output | 4 | Way chosen by the last victim search |
| victim_valid | output | 1 | Last victim search found an unpinned way |
| rrpv_flat | output | 32 | RRPV of way i at bits [2i+1:2i] |
| pin_flat | output | 16 | Pin bit of way i at bit i |
| tex_flat | output | 32 | Texture state of way i at bits [2i+1:2i] |

## Verification
Every per-way state bit is visible at the ports one cycle after the operation that changes it. A wrong update to an RRPV, pin or texture state therefore shows up at the very next sample. An error in the aging arithmetic or the victim priority appears on the cycle after the search that exposes it. The bench follows a long stream of operations with a model that ages the ways one step at a time and compares every output after every operation. This makes a wrong victim choice, a missed release of a pinned way or a skipped texture transition visible within one cycle.

// File: rtl/rrip_pin_set.sv
module rrip_pin_set #(
  parameter int WAYS = 16,
  parameter int RW   = 2,
  parameter int SW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [1:0]           op,
  input  logic [$clog2(WAYS)-1:0] way,
  input  logic [SW-1:0]        stream,
  input  logic                 pin_req,
  input  logic [RW-1:0]        insert_rrpv,
  input  logic [RW-1:0]        promote_rrpv,
  output logic [$clog2(WAYS)-1:0] victim_way,
  output logic                 victim_valid,
  output logic [WAYS*RW-1:0]   rrpv_flat,
  output logic [WAYS-1:0]      pin_flat,
  output logic [WAYS*2-1:0]    tex_flat
);
  localparam int WW = $clog2(WAYS);
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_FILL = 2'd2, OP_VIC = 2'd3;
  localparam logic [SW-1:0] S_COLOR = SW'(1), S_DEPTH = SW'(2), S_BLIT = SW'(3), S_TEX = SW'(4);

  logic [RW-1:0] rrpv_q [WAYS];
  logic [RW-1:0] rrpv_n [WAYS];
  logic [1:0]    tex_q  [WAYS];
  logic [1:0]    tex_n  [WAYS];
  logic [WAYS-1:0] pin_q, pin_n;
  logic [RW-1:0] unp_max, step;
  logic          any_unp, found;
  logic [WW-1:0] vict;
  logic          is_writer, is_tex;

  function automatic logic [RW-1:0] sat_add(input logic [RW-1:0] a, input logic [RW-1:0] b);
    logic [RW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, RMAX}) ? RMAX : s[RW-1:0];
  endfunction

  assign is_writer = (stream == S_COLOR) || (stream == S_DEPTH) || (stream == S_BLIT);
  assign is_tex    = (stream == S_TEX);

  always_comb begin
    any_unp = 1'b0;
    unp_max = '0;
    for (int i = 0; i < WAYS; i++)
      if (!pin_q[i] && rrpv_q[i] >= unp_max) begin
        any_unp = 1'b1;
        unp_max = rrpv_q[i];
      end
    found = 1'b0;
    vict  = '0;
    for (int i = 0; i < WAYS; i++)
      if (!found && !pin_q[i] && rrpv_q[i] == unp_max) begin
        found = 1'b1;
        vict  = WW'(i);
      end
    step = any_unp ? (RMAX - unp_max) : RW'(1);
  end

  always_comb begin
    pin_n = pin_q;
    for (int i = 0; i < WAYS; i++) begin
      rrpv_n[i] = rrpv_q[i];
      tex_n[i]  = tex_q[i];
    end
    if (op_valid) begin
      case (op)
        OP_RD: begin
          rrpv_n[way] = promote_rrpv;
          pin_n[way]  = 1'b0;
          if (is_tex) begin
            if (tex_q[way] == 2'b01) tex_n[way] = 2'b10;
            else if (tex_q[way] == 2'b10) tex_n[way] = 2'b11;
          end
        end
        OP_WR: begin
          rrpv_n[way] = promote_rrpv;
          if (pin_req) pin_n[way] = 1'b1;
          if (is_writer) tex_n[way] = 2'b01;
        end
        OP_FILL: begin
          rrpv_n[way] = insert_rrpv;
          pin_n[way]  = pin_req;
          tex_n[way]  = 2'b00;
        end
        default: begin
          for (int i = 0; i < WAYS; i++)
            rrpv_n[i] = sat_add(rrpv_q[i], step);
        end
      endcase
    end
    for (int i = 0; i < WAYS; i++)
      if (pin_n[i] && rrpv_n[i] == RMAX) begin
        pin_n[i]  = 1'b0;
        rrpv_n[i] = '0;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q        <= '0;
      victim_valid <= 1'b0;
      victim_way   <= '0;
      for (int i = 0; i < WAYS; i++) begin
        rrpv_q[i] <= RMAX;
        tex_q[i]  <= 2'b00;
      end
    end else begin
      pin_q <= pin_n;
      for (int i = 0; i < WAYS; i++) begin
        rrpv_q[i] <= rrpv_n[i];
        tex_q[i]  <= tex_n[i];
      end
      if (op_valid && op == OP_VIC) begin
        victim_valid <= any_unp;
        victim_way   <= any_unp ? vict : '0;
      end
    end
  end

  assign pin_flat = pin_q;
  for (genvar g = 0; g < WAYS; g++) begin : g_flat
    assign rrpv_flat[g*RW +: RW] = rrpv_q[g];
    assign tex_flat[g*2 +: 2]    = tex_q[g];

    p_pin_below_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_q[g] |-> rrpv_q[g] != RMAX);
  end

  p_victim_unpinned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && $past(op_valid && op == OP_VIC)) |-> (!pin_q[victim_way] && rrpv_q[victim_way] == RMAX));

  p_all_pinned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_VIC && (&pin_q)) |=> !victim_valid);

  p_read_unpins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_RD) |=> !pin_q[$past(way)]);

  p_fill_tex_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_FILL) |=> tex_q[$past(way)] == 2'b00);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(victim_way) && $stable(victim_valid) && $stable(pin_q)));
endmodule

// File: tb/test_rrip_pin_set.sv
module test_rrip_pin_set;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 16;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, pin_req = 1'b0;
  logic [1:0] op = 2'd0, insert_rrpv = 2'd0, promote_rrpv = 2'd0;
  logic [3:0] way = 4'd0;
  logic [2:0] stream = 3'd0;
  logic [3:0] victim_way;
  logic victim_valid;
  logic [31:0] rrpv_flat, tex_flat;
  logic [15:0] pin_flat;

  int checks = 0, errors = 0;
  int m_r [WAYS];
  int m_t [WAYS];
  bit m_p [WAYS];
  bit m_vv = 1'b0;
  int m_vw = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrip_pin_set i_rrip_pin_set (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .way(way),
    .stream(stream), .pin_req(pin_req), .insert_rrpv(insert_rrpv),
    .promote_rrpv(promote_rrpv), .victim_way(victim_way), .victim_valid(victim_valid),
    .rrpv_flat(rrpv_flat), .pin_flat(pin_flat), .tex_flat(tex_flat));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] er, et;
    logic [15:0] ep;
    for (int i = 0; i < WAYS; i++) begin
      er[i*2 +: 2] = 2'(m_r[i]);
      et[i*2 +: 2] = 2'(m_t[i]);
      ep[i] = m_p[i];
    end
    chk({tag, " rrpv"}, rrpv_flat, er);
    chk({tag, " pin"}, {16'd0, pin_flat}, {16'd0, ep});
    chk({tag, " tex"}, tex_flat, et);
    chk({tag, " victim"}, {27'd0, victim_valid, victim_way}, {27'd0, m_vv, 4'(m_vw)});
  endtask

  function automatic void release_ways();
    for (int i = 0; i < WAYS; i++)
      if (m_p[i] && m_r[i] == 3) begin m_p[i] = 0; m_r[i] = 0; end
  endfunction

  function automatic void model(input bit v, input int o, input int w, input int s,
                                input bit pr, input int ins, input int pro);
    bit rel [WAYS];
    int f;
    bit any;
    if (!v) return;
    case (o)
      0: begin
        m_r[w] = pro; m_p[w] = 0;
        if (s == 4 && m_t[w] == 1) m_t[w] = 2;
        else if (s == 4 && m_t[w] == 2) m_t[w] = 3;
      end
      1: begin
        m_r[w] = pro; if (pr) m_p[w] = 1;
        if (s >= 1 && s <= 3) m_t[w] = 1;
        release_ways();
      end
      2: begin
        m_r[w] = ins; m_p[w] = pr; m_t[w] = 0;
        release_ways();
      end
      default: begin
        any = 0;
        for (int i = 0; i < WAYS; i++) if (!m_p[i]) any = 1;
        if (!any) begin
          for (int i = 0; i < WAYS; i++) if (m_r[i] < 3) m_r[i]++;
          release_ways();
          m_vv = 0; m_vw = 0;
        end else begin
          for (int i = 0; i < WAYS; i++) rel[i] = 0;
          f = -1;
          for (int k = 0; k < 4 && f < 0; k++) begin
            for (int i = 0; i < WAYS; i++)
              if (f < 0 && !m_p[i] && !rel[i] && m_r[i] == 3) f = i;
            if (f < 0)
              for (int i = 0; i < WAYS; i++)
                if (!rel[i]) begin
                  if (m_r[i] < 3) m_r[i]++;
                  if (m_p[i] && m_r[i] == 3) begin m_p[i] = 0; m_r[i] = 0; rel[i] = 1; end
                end
          end
          m_vv = 1; m_vw = f;
        end
      end
    endcase
  endfunction

  task automatic step(input bit v, input int o, input int w, input int s,
                      input bit pr, input int ins, input int pro, input string tag);
    op_valid = v; op = 2'(o); way = 4'(w); stream = 3'(s);
    pin_req = pr; insert_rrpv = 2'(ins); promote_rrpv = 2'(pro);
    model(v, o, w, s, pr, ins, pro);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    string tg;
    for (int i = 0; i < WAYS; i++) begin m_r[i] = 3; m_p[i] = 0; m_t[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");

    step(1, 3, 0, 0, 0, 0, 0, "R5 search from reset");
    step(1, 2, 0, 0, 0, 2, 0, "R4 fill");
    step(1, 3, 0, 0, 0, 0, 0, "R5 skip way0");
    step(1, 0, 1, 0, 0, 0, 1, "R2 read hit");
    for (int i = 0; i < WAYS; i++) step(1, 2, i, 0, 1, 0, 0, "R4 pinned fill");
    step(1, 3, 0, 0, 0, 0, 0, "R7 all pinned");
    step(1, 3, 0, 0, 0, 0, 0, "R7 all pinned again");
    step(1, 3, 0, 0, 0, 0, 0, "R6 release on third aging");
    step(1, 1, 5, 1, 1, 0, 3, "R6 pinned write at max released");
    step(1, 1, 6, 2, 0, 0, 1, "R8 depth write");
    step(1, 0, 6, 4, 0, 0, 1, "R9 sampler read 01 to 10");
    step(1, 0, 6, 4, 0, 0, 1, "R9 sampler read 10 to 11");
    step(1, 0, 6, 4, 0, 0, 0, "R9 sampler read holds 11");
    step(1, 0, 6, 0, 0, 0, 0, "R9 generic read");
    step(0, 2, 6, 1, 1, 1, 1, "R10 idle");

    for (int n = 0; n < 4000; n++) begin
      x = rnd();
      case (x[1:0])
        2'd0: tg = "R2 R9 sweep read";
        2'd1: tg = "R3 R8 sweep write";
        2'd2: tg = "R4 sweep fill";
        default: tg = "R5 R6 R7 sweep search";
      endcase
      if (x[20:18] == 3'd0) tg = "R10 sweep idle";
      step(x[20:18] != 3'd0, int'(x[1:0]), int'(x[5:2]), int'(x[8:6]),
           x[10:9] != 2'd0, int'(x[12:11]), x[15] ? int'(x[14:13]) : 0, tg);
    end

    op_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule